// File: doc/BRIEF.md
# Radix-4 Booth Signed Multiplier

This block multiplies two two's-complement operands in a single combinational pass. The multiplier operand is recoded into radix-4 digits. Each digit is taken from an overlapping window of three multiplier bits and has a value in {-2, -1, 0, +1, +2}. The number of partial products is therefore about half the multiplier width. Only the easy multiples of the multiplicand (zero, once, twice) are ever formed, and a difficult triple multiple is never needed.

Each digit has an encoder slice that drives three strobes: select-once, select-twice and negate. A row of selector cells turns these strobes into the bits of one partial product. Negation inverts the selected multiple and adds a one at that row's lowest weight. All of these correction ones are gathered into one extra row. The rows are sign-extended to the full product width. A tree of 3:2 carry-save rows reduces them to two vectors, and one carry-propagate addition produces the exact product.

The operand widths are independent parameters. An odd multiplier width is handled by sign-extending the multiplier up to a whole number of digits.

Top module: `boothMultiplier`

## Requirements
- R1: With default widths (8 x 8), `product` equals the exact signed product of `mcand` and `mplr` for every operand pair, in the same evaluation as the operands.
- R2: Digit i is formed from the multiplier bits (x[2i+1], x[2i], x[2i-1]) with x[-1] = 0, and its value is -2*x[2i+1] + x[2i] + x[2i-1]. A magnitude of one raises select-once, a magnitude of two raises select-twice, and a negative value raises negate.
- R3: Select-once and select-twice are never both raised for the same digit.
- R4: Negate is raised only for a digit with a nonzero magnitude, so no digit is encoded as minus zero.
- R5: Products of the most negative operand are exact: (-128)*(-128) = +16384 and (-128)*127 = -16256.
- R6: When either operand is zero, `product` is zero.
- R7: A 16 x 16 configuration gives the exact signed 32-bit product.
- R8: An odd multiplier width is sign-extended to a whole number of digits. A 6 x 5 configuration gives the exact signed 11-bit product for every pair.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mcand | input | MCAND_W | Multiplicand, two's-complement |
| mplr | input | MPLR_W | Multiplier, two's-complement, Booth-recoded |
| product | output | MCAND_W+MPLR_W | Signed product, full width |

## Verification
The corner cases pursued are the multiples that need negation or doubling at the sign boundary. If the top extension bit of the doubled multiplicand were dropped, products with -128 would be wrong by a power of two. If the correction one were misplaced, every negative digit would be off by a shifted unit. The odd-width configuration shows whether the multiplier is sign-extended or zero-padded: zero-padding flips the sign of every product with a negative multiplier. Every three-bit digit window is driven explicitly, so a wrong entry in the recoding gives a wrong product for that window.

// File: rtl/boothPkg.sv
package boothPkg;

  typedef struct packed {
    logic selOne;
    logic selTwo;
    logic negate;
  } boothCtrl_t;

  function automatic int rowsAfter(int rows, int stages);
    int n;
    n = rows;
    for (int k = 0; k < stages; k++) n = 2 * (n / 3) + (n % 3);
    return n;
  endfunction

  function automatic int stagesFor(int rows);
    int n;
    int s;
    n = rows;
    s = 0;
    while (n > 2) begin
      n = 2 * (n / 3) + (n % 3);
      s++;
    end
    return s;
  endfunction

endpackage

// File: rtl/boothEncoder.sv
module boothEncoder
  import boothPkg::*;
#(
  parameter int DIGITS = 4
) (
  input  logic [2*DIGITS:0]        xPad,
  output boothCtrl_t [DIGITS-1:0]  ctrl
);

  for (genvar i = 0; i < DIGITS; i++) begin : gDigit
    logic xLo, xMid, xHi;
    assign xLo  = xPad[2*i];
    assign xMid = xPad[2*i+1];
    assign xHi  = xPad[2*i+2];
    assign ctrl[i] = '{
      selOne: xMid ^ xLo,
      selTwo: (xHi & ~xMid & ~xLo) | (~xHi & xMid & xLo),
      negate: xHi & ~(xMid & xLo)
    };
  end

endmodule

// File: rtl/boothPpGen.sv
module boothPpGen
  import boothPkg::*;
#(
  parameter int MCAND_W = 8,
  parameter int DIGITS  = 4,
  parameter int PROD_W  = 16,
  localparam int ROWS   = DIGITS + 1
) (
  input  logic [MCAND_W-1:0]           mcand,
  input  boothCtrl_t [DIGITS-1:0]      ctrl,
  output logic [ROWS-1:0][PROD_W-1:0]  rows
);

  logic [MCAND_W:0] yExt;
  assign yExt = {mcand[MCAND_W-1], mcand};

  for (genvar i = 0; i < DIGITS; i++) begin : gRow
    logic [MCAND_W:0] multiple;
    for (genvar j = 0; j <= MCAND_W; j++) begin : gCell
      if (j == 0) begin : gLsb
        assign multiple[j] = (ctrl[i].selOne & yExt[0]) ^ ctrl[i].negate;
      end else begin : gUpper
        assign multiple[j] = ((ctrl[i].selOne & yExt[j]) |
                              (ctrl[i].selTwo & yExt[j-1])) ^ ctrl[i].negate;
      end
    end
    assign rows[i] = PROD_W'($signed(multiple)) << (2 * i);
  end

  logic [PROD_W-1:0] negBits;
  always_comb begin
    negBits = '0;
    for (int i = 0; i < DIGITS; i++) negBits[2*i] = ctrl[i].negate;
  end
  assign rows[DIGITS] = negBits;

endmodule

// File: rtl/csaRow.sv
module csaRow #(
  parameter int W = 16
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic [W-1:0] c,
  output logic [W-1:0] sum,
  output logic [W-1:0] carry
);

  assign sum   = a ^ b ^ c;
  assign carry = ((a & b) | (a & c) | (b & c)) << 1;

endmodule

// File: rtl/csaTree.sv
module csaTree
  import boothPkg::*;
#(
  parameter int ROWS   = 5,
  parameter int PROD_W = 16
) (
  input  logic [ROWS-1:0][PROD_W-1:0] rowsIn,
  output logic [PROD_W-1:0]           sumOut,
  output logic [PROD_W-1:0]           carryOut
);

  localparam int STAGES = stagesFor(ROWS);

  for (genvar s = 0; s < STAGES; s++) begin : stg
    localparam int NIN  = rowsAfter(ROWS, s);
    localparam int NOUT = rowsAfter(ROWS, s + 1);
    localparam int GRP  = NIN / 3;
    logic [NIN-1:0][PROD_W-1:0]  vin;
    logic [NOUT-1:0][PROD_W-1:0] vout;

    if (s == 0) begin : gFirst
      assign vin = rowsIn;
    end else begin : gLater
      assign vin = stg[s-1].vout;
    end

    for (genvar g = 0; g < GRP; g++) begin : gCsa
      csaRow #(.W(PROD_W)) uRow (
        .a    (vin[3*g]),
        .b    (vin[3*g+1]),
        .c    (vin[3*g+2]),
        .sum  (vout[2*g]),
        .carry(vout[2*g+1])
      );
    end
    for (genvar r = 0; r < NIN % 3; r++) begin : gPass
      assign vout[2*GRP+r] = vin[3*GRP+r];
    end
  end

  if (STAGES == 0) begin : gDirect
    assign sumOut   = rowsIn[0];
    assign carryOut = rowsIn[ROWS-1];
  end else begin : gReduced
    assign sumOut   = stg[STAGES-1].vout[0];
    assign carryOut = stg[STAGES-1].vout[1];
  end

endmodule

// File: rtl/boothMultiplier.sv
module boothMultiplier
  import boothPkg::*;
#(
  parameter int MCAND_W = 8,
  parameter int MPLR_W  = 8
) (
  input  logic [MCAND_W-1:0]        mcand,
  input  logic [MPLR_W-1:0]         mplr,
  output logic [MCAND_W+MPLR_W-1:0] product
);

  localparam int PROD_W = MCAND_W + MPLR_W;
  localparam int DIGITS = (MPLR_W + 1) / 2;
  localparam int ROWS   = DIGITS + 1;

  logic [2*DIGITS:0]          xPad;
  boothCtrl_t [DIGITS-1:0]    ctrlBus;
  logic [ROWS-1:0][PROD_W-1:0] ppRows;
  logic [PROD_W-1:0]          sumVec;
  logic [PROD_W-1:0]          carryVec;

  assign xPad = {(2 * DIGITS)'($signed(mplr)), 1'b0};

  boothEncoder #(.DIGITS(DIGITS)) uEnc (
    .xPad(xPad),
    .ctrl(ctrlBus)
  );

  boothPpGen #(.MCAND_W(MCAND_W), .DIGITS(DIGITS), .PROD_W(PROD_W)) uPp (
    .mcand(mcand),
    .ctrl (ctrlBus),
    .rows (ppRows)
  );

  csaTree #(.ROWS(ROWS), .PROD_W(PROD_W)) uTree (
    .rowsIn  (ppRows),
    .sumOut  (sumVec),
    .carryOut(carryVec)
  );

  assign product = sumVec + carryVec;

endmodule

// File: rtl/boothMultiplierChecker.sv
module boothMultiplierChecker
  import boothPkg::*;
#(
  parameter int MCAND_W = 8,
  parameter int MPLR_W  = 8,
  parameter int DIGITS  = (MPLR_W + 1) / 2
) (
  input logic [MCAND_W-1:0]        mcand,
  input logic [MPLR_W-1:0]         mplr,
  input logic [MCAND_W+MPLR_W-1:0] product,
  input boothCtrl_t [DIGITS-1:0]   ctrlBus
);

  localparam int PROD_W = MCAND_W + MPLR_W;

  logic [PROD_W-1:0] refProd;
  logic [2*DIGITS:0] xPad;
  assign refProd = PROD_W'($signed(mcand)) * PROD_W'($signed(mplr));
  assign xPad    = {(2 * DIGITS)'($signed(mplr)), 1'b0};

  always_comb begin
    int want;
    int got;
    assert_exact_product_R1: assert (product == refProd);
    assert_zero_operand_R6: assert (!(mcand == '0 || mplr == '0) || product == '0);
    for (int i = 0; i < DIGITS; i++) begin
      want = int'(xPad[2*i]) + int'(xPad[2*i+1]) - 2 * int'(xPad[2*i+2]);
      got  = ctrlBus[i].selTwo ? 2 : (ctrlBus[i].selOne ? 1 : 0);
      if (ctrlBus[i].negate) got = -got;
      assert_digit_value_R2: assert (got == want);
      assert_one_magnitude_R3: assert (!(ctrlBus[i].selOne && ctrlBus[i].selTwo));
      assert_no_minus_zero_R4: assert (!ctrlBus[i].negate || ctrlBus[i].selOne || ctrlBus[i].selTwo);
    end
  end

endmodule

bind boothMultiplier boothMultiplierChecker #(.MCAND_W(MCAND_W), .MPLR_W(MPLR_W)) uChk (
  .mcand  (mcand),
  .mplr   (mplr),
  .product(product),
  .ctrlBus(ctrlBus)
);

// File: tb/boothMultiplier_test.sv
module boothMultiplier_test;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 150000;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  logic [7:0]  a8, b8;
  logic [15:0] p8;
  logic [15:0] a16, b16;
  logic [31:0] p16;
  logic [5:0]  a6;
  logic [4:0]  b5;
  logic [10:0] p65;

  int checkCount = 0;
  int failCount  = 0;
  bit finished   = 1'b0;

  boothMultiplier #(.MCAND_W(8), .MPLR_W(8)) uut (
    .mcand(a8), .mplr(b8), .product(p8));
  boothMultiplier #(.MCAND_W(16), .MPLR_W(16)) uutWide (
    .mcand(a16), .mplr(b16), .product(p16));
  boothMultiplier #(.MCAND_W(6), .MPLR_W(5)) uutOdd (
    .mcand(a6), .mplr(b5), .product(p65));

  task automatic compare(input string req, input longint got, input longint exp);
    checkCount++;
    if (got != exp) begin
      failCount++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  task automatic apply8(input logic [7:0] a, input logic [7:0] b, input string req);
    @(posedge clk);
    a8 = a;
    b8 = b;
    @(negedge clk);
    compare(req, longint'($signed(p8)), longint'($signed(a)) * longint'($signed(b)));
  endtask

  task automatic apply16(input logic [15:0] a, input logic [15:0] b, input string req);
    @(posedge clk);
    a16 = a;
    b16 = b;
    @(negedge clk);
    compare(req, longint'($signed(p16)), longint'($signed(a)) * longint'($signed(b)));
  endtask

  task automatic apply65(input logic [5:0] a, input logic [4:0] b, input string req);
    @(posedge clk);
    a6 = a;
    b5 = b;
    @(negedge clk);
    compare(req, longint'($signed(p65)), longint'($signed(a)) * longint'($signed(b)));
  endtask

  task automatic testRestState;
    @(negedge clk);
    compare("R6 rest 8x8", longint'($signed(p8)), 0);
    compare("R6 rest 16x16", longint'($signed(p16)), 0);
    compare("R6 rest 6x5", longint'($signed(p65)), 0);
  endtask

  task automatic testExhaustive8;
    for (int a = 0; a < 256; a++)
      for (int b = 0; b < 256; b++)
        apply8(8'(a), 8'(b), "R1 exhaustive");
  endtask

  task automatic testDigitTriplets;
    // every three-bit window appears as digit 1 (bits 3..1) and as digit 0 with x[-1] = 0
    for (int t = 0; t < 8; t++) begin
      apply8(8'h01, 8'(t << 1), "R2 R3 R4 window unit");
      apply8(8'h5B, 8'(t << 1), "R2 R3 R4 window pos");
      apply8(8'hA7, 8'(t << 1), "R2 R3 R4 window neg");
      apply8(8'h33, 8'(t), "R2 low window");
    end
  endtask

  task automatic testExtremes;
    apply8(8'h80, 8'h80, "R5 min*min");
    compare("R5 min*min value", longint'($signed(p8)), 16384);
    apply8(8'h80, 8'h7F, "R5 min*max");
    compare("R5 min*max value", longint'($signed(p8)), -16256);
    apply8(8'h7F, 8'h80, "R5 max*min");
    apply8(8'h80, 8'hFF, "R5 min*-1");
    apply8(8'hFF, 8'hFF, "R5 -1*-1");
    apply16(16'h8000, 16'h8000, "R5 R7 min*min wide");
    apply16(16'h8000, 16'h7FFF, "R5 R7 min*max wide");
  endtask

  task automatic testZeroOperands;
    for (int k = 0; k < 16; k++) begin
      apply8(8'h00, 8'($urandom), "R6 zero mcand");
      apply8(8'($urandom), 8'h00, "R6 zero mplr");
    end
    apply16(16'h0000, 16'h8000, "R6 zero wide");
  endtask

  task automatic testWideRandom;
    for (int k = 0; k < 3000; k++)
      apply16(16'($urandom), 16'($urandom), "R7 random wide");
    apply16(16'hFFFF, 16'h7FFF, "R7 -1*max");
    apply16(16'h5555, 16'hAAAA, "R7 alternating");
  endtask

  task automatic testOddWidth;
    for (int a = 0; a < 64; a++)
      for (int b = 0; b < 32; b++)
        apply65(6'(a), 5'(b), "R8 odd width");
  endtask

  task automatic finishRun;
    if (!finished) begin
      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checkCount, failCount);
      $finish;
    end
  endtask

  initial begin
    a8 = '0; b8 = '0; a16 = '0; b16 = '0; a6 = '0; b5 = '0;
    repeat (4) @(posedge clk);
    rstN = 1'b1;
    testRestState();
    testExhaustive8();
    testDigitTriplets();
    testExtremes();
    testZeroOperands();
    testWideRandom();
    testOddWidth();
    finishRun();
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    checkCount++;
    failCount++;
    $display("FAIL watchdog: got timeout expected completion");
    finishRun();
  end

endmodule